// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block derives a card clock from a reference clock at one of four division ratios (1, 2, 4 or 8). A two-bit select code chooses the ratio. Each reference tick stands for one half period of the clock source, so the reference runs at twice the source frequency. A ratio D drives the output high for D ticks and low for D ticks. All logic runs on the rising edge of the reference, so the output comes straight from a register and cannot glitch.

A ratio change never cuts a pulse short. The select code is registered and must hold still through a settling window. By default the window is sixteen ticks, which is eight source periods. Only then is the new ratio eligible. The switch itself waits until the current low phase has run its full length. The new ratio then begins with a fresh, full-width high phase.

A gate input from the power sequencer starts and stops the clock. When the gate drops, any high phase in progress still runs to its full width, and the output then stays low. When the gate rises, a high phase begins as soon as the current low phase has lasted its full length.

Top module: `card_clk_divider`

## Requirements
- R1: While reset is asserted, and from then on until the gate is raised, the output is low. The active select code after reset is 00 (divide by 8) and no change is pending.
- R2: Select code 00 gives divide by 8, 01 divide by 4, 11 divide by 2 and 10 divide by 1. Divide by D means each high phase and each steady low phase lasts exactly D reference ticks.
- R3: A new select code is registered one tick after it is applied. It must then stay unchanged for SETTLE_TICKS ticks (default 16) before it can be adopted. Any change inside that window restarts the window.
- R4: A new ratio is adopted only at the end of a complete low phase of the old ratio. The first high phase afterwards has the full width of the new ratio. No high phase is ever shorter than the half period of the ratio it belongs to.
- R5: When the gate is low, a high phase in progress completes at full width, and the output then remains low for as long as the gate stays low.
- R6: When the gate is high and the output has been low for at least the current half period, the output goes high on the next reference tick.
- R7: A select code that is changed away and back to the active code before its window completes leaves the ratio unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock, one tick per source half period |
| rstIn | input | 1 | Synchronous reset, active high |
| selIn | input | SEL_W | Ratio select code (Gray-ordered) |
| gateEn | input | 1 | Clock enable from the sequencer, active high |
| cardClk | output | 1 | Divided card clock, registered |

## Verification
The hardest situations to reach are a ratio change that becomes eligible in the middle of a long high phase, and a select change that is withdrawn or replaced before its window expires. Either one would expose a truncated pulse or a premature switch. The stimulus reads the output phase at the ports and places select edges at known offsets within a high phase. It also changes the select code several ticks before the window closes and changes the ratio while the gate is off. A tick-by-tick behavioural model, built on integer run lengths, checks every output sample through these sequences.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  // Strobes from the control to the datapath, one tick wide each.
  typedef struct packed {
    logic goHigh;  // end of a full low phase with the gate open
    logic goLow;   // end of a full high phase
    logic adopt;   // load the settled code as the active ratio
  } cdivStrobe_t;

  // Converts a Gray-ordered select code into its ordinal position.
  // Bit i of the ordinal is the XOR of code bit i and ordinal bit i+1.
  function automatic int grayToBin(input int code, input int width);
    int bin;
    bin = 0;
    for (int i = width - 1; i >= 0; i--) begin
      bin = bin | ((((code >> i) & 1) ^ ((bin >> (i + 1)) & 1)) << i);
    end
    return bin;
  endfunction

endpackage

// File: rtl/cdiv_ctrl.sv
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter int             SEL_W        = 2,
  parameter int             SETTLE_TICKS = 16,
  parameter logic [SEL_W-1:0] RST_SEL    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  selIn,
  input  logic              gateEn,
  input  logic              clkLvl,
  input  logic              phaseDone,
  input  logic [SEL_W-1:0]  activeSel,
  output cdivStrobe_t       strobe,
  output logic [SEL_W-1:0]  pendSel
);

  localparam int AGE_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [AGE_W-1:0] AGE_FULL = AGE_W'(SETTLE_TICKS);

  logic [SEL_W-1:0] selReg;
  logic [SEL_W-1:0] pendReg;
  logic [AGE_W-1:0] ageCnt;
  logic             settled;
  logic             switchReady;
  logic             lowDone;
  logic             highDone;

  // Select capture and settling window.
  always_ff @(posedge clk) begin
    if (rst) begin
      selReg  <= RST_SEL;
      pendReg <= RST_SEL;
      ageCnt  <= AGE_FULL;
    end else begin
      selReg <= selIn;
      if (selReg != pendReg) begin
        pendReg <= selReg;
        ageCnt  <= '0;
      end else if (!settled) begin
        ageCnt <= ageCnt + 1'b1;
      end
    end
  end

  assign settled     = (ageCnt == AGE_FULL);
  assign switchReady = settled && (pendReg != activeSel);
  assign pendSel     = pendReg;

  // Phase decisions.
  always_comb begin
    lowDone       = !clkLvl && phaseDone;
    highDone      = clkLvl && phaseDone;
    strobe        = '0;
    strobe.goLow  = highDone;
    strobe.goHigh = lowDone && gateEn;
    strobe.adopt  = lowDone && switchReady;
  end

  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (rst)
    (selReg != pendReg) |=> !strobe.adopt); // R3

  AST_ADOPT_LOADS: assert property (@(posedge clk) disable iff (rst)
    strobe.adopt |=> (activeSel == $past(pendReg))); // R3

endmodule

// File: rtl/cdiv_datapath.sv
module cdiv_datapath
  import cdiv_pkg::*;
#(
  parameter int               SEL_W   = 2,
  parameter logic [SEL_W-1:0] RST_SEL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  cdivStrobe_t       strobe,
  input  logic [SEL_W-1:0]  adoptSel,
  output logic              clkOut,
  output logic              phaseDone,
  output logic [SEL_W-1:0]  activeSel
);

  localparam int NCODES    = 1 << SEL_W;
  localparam int MAX_SHIFT = NCODES - 1;
  localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'((1 << MAX_SHIFT) - 1);

  logic [CNT_W-1:0] lastIdxTab [NCODES];
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] halfCnt;

  // Half-period lookup: each code maps to a power-of-two phase length.
  for (genvar c = 0; c < NCODES; c++) begin : g_ratio
    localparam int SHIFT = MAX_SHIFT - grayToBin(c, SEL_W);
    assign lastIdxTab[c] = CNT_W'((1 << SHIFT) - 1);
  end

  assign lastIdx   = lastIdxTab[activeSel];
  assign phaseDone = (halfCnt >= lastIdx);

  always_ff @(posedge clk) begin
    if (rst) begin
      clkOut    <= 1'b0;
      halfCnt   <= CNT_MAX;
      activeSel <= RST_SEL;
    end else begin
      if (strobe.adopt) begin
        activeSel <= adoptSel;
      end
      if (strobe.goLow) begin
        clkOut  <= 1'b0;
        halfCnt <= '0;
      end else if (strobe.goHigh) begin
        clkOut  <= 1'b1;
        halfCnt <= '0;
      end else if (halfCnt != CNT_MAX) begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> !clkOut); // R1

  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
    clkOut |-> (halfCnt <= lastIdx)); // R2

  AST_HIGH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (clkOut && !phaseDone) |=> clkOut); // R4

  AST_SWITCH_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(activeSel) |-> !$past(clkOut)); // R4

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
  import cdiv_pkg::*;
#(
  parameter int               SEL_W        = 2,
  parameter int               SETTLE_TICKS = 16,
  parameter logic [SEL_W-1:0] RST_SEL      = '0
) (
  input  logic             refClk,
  input  logic             rstIn,
  input  logic [SEL_W-1:0] selIn,
  input  logic             gateEn,
  output logic             cardClk
);

  cdivStrobe_t      strobe;
  logic [SEL_W-1:0] pendSel;
  logic [SEL_W-1:0] activeSel;
  logic             phaseDone;
  logic             clkLvl;

  cdiv_ctrl #(
    .SEL_W        (SEL_W),
    .SETTLE_TICKS (SETTLE_TICKS),
    .RST_SEL      (RST_SEL)
  ) ctrl_i (
    .clk       (refClk),
    .rst       (rstIn),
    .selIn     (selIn),
    .gateEn    (gateEn),
    .clkLvl    (clkLvl),
    .phaseDone (phaseDone),
    .activeSel (activeSel),
    .strobe    (strobe),
    .pendSel   (pendSel)
  );

  cdiv_datapath #(
    .SEL_W   (SEL_W),
    .RST_SEL (RST_SEL)
  ) dp_i (
    .clk       (refClk),
    .rst       (rstIn),
    .strobe    (strobe),
    .adoptSel  (pendSel),
    .clkOut    (clkLvl),
    .phaseDone (phaseDone),
    .activeSel (activeSel)
  );

  assign cardClk = clkLvl;

  AST_GATE_HOLD: assert property (@(posedge refClk) disable iff (rstIn)
    (!gateEn && !cardClk) |=> !cardClk); // R5

endmodule

// File: tb/card_clk_divider_tb_top.sv
module card_clk_divider_tb_top;

  localparam int SETTLE = 16;

  logic       refClk = 1'b0;
  logic       rstIn  = 1'b1;
  logic       gateEn = 1'b0;
  logic [1:0] selIn  = 2'b00;
  logic       cardClk;

  always #5 refClk = ~refClk;

  card_clk_divider #(
    .SEL_W        (2),
    .SETTLE_TICKS (SETTLE),
    .RST_SEL      (2'b00)
  ) dut_i (
    .refClk  (refClk),
    .rstIn   (rstIn),
    .selIn   (selIn),
    .gateEn  (gateEn),
    .cardClk (cardClk)
  );

  int total  = 0;
  int bad    = 0;
  int cycles = 0;
  bit modelOn = 1'b0;
  bit doneRun = 1'b0;

  // Behavioural reference: level, run length, active/pending codes, age.
  logic       mLvl;
  int         mRun;
  logic [1:0] mAct;
  logic [1:0] mPend;
  int         mAge;
  logic [1:0] mSreg;

  function automatic int halfOf(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 4;
      2'b11:   return 2;
      default: return 1;
    endcase
  endfunction

  always @(posedge refClk) begin
    int  hl;
    bit  rdy;
    cycles++;
    if (rstIn) begin
      mLvl = 1'b0; mRun = 100; mAct = 2'b00; mPend = 2'b00;
      mAge = SETTLE; mSreg = 2'b00;
    end else begin
      hl  = halfOf(mAct);
      rdy = (mAge >= SETTLE) && (mPend != mAct);
      if (mLvl) begin
        if (mRun >= hl) begin mLvl = 1'b0; mRun = 1; end
        else mRun++;
      end else if (mRun >= hl) begin
        if (rdy) mAct = mPend;
        if (gateEn) begin mLvl = 1'b1; mRun = 1; end
        else mRun++;
      end else begin
        mRun++;
      end
      if (mSreg != mPend) begin mPend = mSreg; mAge = 0; end
      else if (mAge < SETTLE) mAge++;
      mSreg = selIn;
    end
  end

  always @(negedge refClk) begin
    if (modelOn && !rstIn && !doneRun) begin
      total++;
      if (cardClk !== mLvl) begin
        bad++;
        $display("FAIL R2/R4/R6 tick model at cycle %0d: actual=%0b expected=%0b",
                 cycles, cardClk, mLvl);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    doneRun = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic waitRise();
    @(negedge refClk);
    while (cardClk !== 1'b0) @(negedge refClk);
    while (cardClk !== 1'b1) @(negedge refClk);
  endtask

  // Width of the next full high phase and of the low phase after it.
  task automatic measPair(output int hi, output int lo);
    waitRise();
    hi = 0;
    while (cardClk === 1'b1) begin hi++; @(negedge refClk); end
    lo = 0;
    while (cardClk === 1'b0) begin lo++; @(negedge refClk); end
  endtask

  // Longest high run seen over n samples.
  task automatic maxHighOver(input int n, output int mx);
    int run;
    run = 0; mx = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge refClk);
      if (cardClk === 1'b1) begin run++; if (run > mx) mx = run; end
      else run = 0;
    end
  endtask

  initial begin
    wait (cycles >= 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
    finishRun();
  end

  initial begin
    int hi, lo, mx, highs, w;
    int widths[$];
    logic [1:0] codes[3];
    codes[0] = 2'b01; codes[1] = 2'b11; codes[2] = 2'b10;

    // R1: reset state and idle low
    repeat (3) @(negedge refClk);
    chk("R1 output low in reset", int'(cardClk), 0);
    rstIn = 1'b0; modelOn = 1'b1;
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge refClk);
      if (cardClk !== 1'b0) highs++;
    end
    chk("R1 low while gate closed", highs, 0);

    // R6: gate opens from idle
    gateEn = 1'b1;
    @(negedge refClk);
    chk("R6 first high on next tick", int'(cardClk), 1);
    w = 0;
    while (cardClk === 1'b1) begin w++; @(negedge refClk); end
    chk("R2 code 00 high width", w, 8);
    lo = 0;
    while (cardClk === 1'b0) begin lo++; @(negedge refClk); end
    chk("R2 code 00 low width", lo, 8);

    // R2: remaining codes in single-bit steps
    for (int k = 0; k < 3; k++) begin
      selIn = codes[k];
      repeat (60) @(negedge refClk);
      measPair(hi, lo);
      chk($sformatf("R2 code %02b high width", codes[k]), hi, halfOf(codes[k]));
      chk($sformatf("R2 code %02b low width", codes[k]), lo, halfOf(codes[k]));
    end

    // R7: change withdrawn inside the window (active code 10)
    selIn = 2'b11;
    repeat (8) @(negedge refClk);
    selIn = 2'b10;
    maxHighOver(60, mx);
    chk("R7 withdrawn change keeps divide by 1", mx, 1);

    // R3: window restarted by a second change
    selIn = 2'b11;
    repeat (10) @(negedge refClk);
    selIn = 2'b01;
    maxHighOver(16, mx);
    chk("R3 no adoption before window ends", mx, 1);
    repeat (60) @(negedge refClk);
    measPair(hi, lo);
    chk("R3 settled code adopted", hi, 4);

    // R5: gate drops mid-high at divide by 8
    selIn = 2'b00;
    repeat (60) @(negedge refClk);
    waitRise();
    w = 1;
    repeat (2) begin @(negedge refClk); if (cardClk === 1'b1) w++; end
    gateEn = 1'b0;
    @(negedge refClk);
    while (cardClk === 1'b1) begin w++; @(negedge refClk); end
    chk("R5 high phase completes at full width", w, 8);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge refClk);
      if (cardClk !== 1'b0) highs++;
    end
    chk("R5 output held low", highs, 0);

    // R4: ratio changed while gated, first pulse uses the new ratio
    selIn = 2'b10;
    repeat (40) @(negedge refClk);
    gateEn = 1'b1;
    @(negedge refClk);
    chk("R6 restart after gate reopens", int'(cardClk), 1);
    w = 0;
    while (cardClk === 1'b1) begin w++; @(negedge refClk); end
    chk("R4 first pulse after gated change", w, 1);

    // R4: change lands in the middle of a long high phase
    selIn = 2'b00;
    repeat (60) @(negedge refClk);
    waitRise();
    repeat (3) @(negedge refClk);
    selIn = 2'b10;
    widths.delete();
    for (int p = 0; p < 5; p++) begin
      measPair(hi, lo);
      widths.push_back(hi);
    end
    highs = 0;
    foreach (widths[i]) if (widths[i] != 8 && widths[i] != 1) highs++;
    chk("R4 no truncated pulse across switch", highs, 0);
    chk("R4 new ratio reached", widths[4], 1);

    // R1: reset during operation
    waitRise();
    rstIn = 1'b1;
    @(negedge refClk);
    chk("R1 reset forces low", int'(cardClk), 0);
    @(negedge refClk);
    rstIn = 1'b0;
    gateEn = 1'b0;
    repeat (5) @(negedge refClk);

    finishRun();
  end

endmodule